// File: doc/BRIEF.md
# Programmable Chip-Select Channel with Wait-State Control

This block decodes one chip-select window on a processor bus. Software programs two 16-bit registers through a simple write/read port. The control register holds the low five address compare bits, a system-management-mode qualifier, a bus-width select, a memory/I/O select, a ready-source select and a wait-state count. The mask register holds the matching don't-care bits. The upper ten compare and mask bits come in as static configuration inputs. Together they give a 15-bit channel address.

When the bus flags a new cycle with `bus_adv`, the block compares the masked channel address against the bus address. It also checks that the cycle type and the management-mode state fit the programmed qualifiers. On a hit it drives the active-low chip-select. It then counts the programmed wait states and ends the cycle in one of two ways: with its own one-cycle ready pulse, or by waiting for an external ready. While the select is active, it reports whether the cycle is 16 bits wide. The parameter `UPPER_CH` selects which reset value the control register takes: the general one or the upper-window one.

Top module: `csel_channel`

## Requirements
- R1: After reset the control register reads 0x0000 when `UPPER_CH`=0 and 0xFF6F when `UPPER_CH`=1. The mask register reads 0x0000. `cs_n` and `int_rdy_n` are high.
- R2: A write with `reg_sel`=0 updates the control register and a write with `reg_sel`=1 updates the mask register. `reg_rdata` shows the register that `reg_sel` selects, and all 16 bits read back as written, reserved bits 6:5 included.
- R3: For a memory cycle, the channel address {`cfg_up_addr`, control[15:11]} is compared with `bus_addr`[25:11]. A 1 in {`cfg_up_mask`, mask[15:11]} makes that bit a don't-care.
- R4: For an I/O cycle, the same masked channel address is compared with `bus_addr`[15:1]. Address bit 0 takes no part in the compare.
- R5: Control bit 8 set to 1 selects memory cycles and 0 selects I/O cycles. A cycle whose `bus_is_mem` differs from bit 8 never asserts `cs_n`.
- R6: If mask bit 10 is 0 and control bit 10 is 1, a hit also needs `bus_smm`=1 and `bus_hold`=0. If mask bit 10 is 0 and control bit 10 is 0, a hit needs `bus_smm`=0. If mask bit 10 is 1, the management-mode state has no effect.
- R7: On a hit, `cs_n` goes low at the clock edge that samples `bus_adv`. It stays low until the edge at which the cycle ends, and it is high in the cycle after that.
- R8: If control bit 7 is 0, with wait count N = control[4:0], `int_rdy_n` is low for exactly one cycle: the (N+1)th cycle of `cs_n` low. That cycle is the last one with `cs_n` low, and N=0 gives a single-cycle select.
- R9: If control bit 7 is 1, `int_rdy_n` stays high. The cycle ends at the first edge at or after the (N+1)th select cycle where `ext_rdy_n` is low. A low `ext_rdy_n` before that point has no effect.
- R10: `cyc_16` is 1 only while `cs_n` is low, control bit 9 is 1 and `bs8_n` is high. Otherwise it is 0.
- R11: A `bus_adv` pulse while a cycle is in progress is ignored, and no new cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cfg_up_addr | input | 10 | Upper channel address bits |
| cfg_up_mask | input | 10 | Upper don't-care bits |
| bus_adv | input | 1 | Address-valid pulse that starts a bus cycle |
| bus_addr | input | 26 | Bus address |
| bus_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| bus_smm | input | 1 | Processor is in system-management mode |
| bus_hold | input | 1 | Processor is in a hold state |
| ext_rdy_n | input | 1 | External ready, active low |
| bs8_n | input | 1 | External 8-bit size request, active low |
| cs_n | output | 1 | Chip-select, active low |
| int_rdy_n | output | 1 | Internally generated ready, active low |
| cyc_16 | output | 1 | Current cycle is 16 bits wide |

## Verification
The bench builds two copies of the block with the default 26-bit address. One copy has `UPPER_CH`=0 and carries all the functional tests. The other has `UPPER_CH`=1 and is used only to read its reset value. Between them they cover both reset layouts. With the default five-bit wait field, a count of 31 is within reach, which shows the longest internal-ready cycle of 32 select cycles. The 26-bit address also places the memory compare (bits 25:11) and the I/O compare (bits 15:1) on separate bit ranges, so a fault that swaps the two shows up.

// File: rtl/csel_pkg.sv
// Shared field layouts and reset constants for the chip-select channel.
// Assumes a 16-bit register width and a 15-bit channel address.
package csel_pkg;
    localparam int REG_W = 16;
    localparam int LO_W  = 5;
    localparam int CH_W  = 15;
    localparam int UP_W  = CH_W - LO_W;
    localparam int WS_W  = 5;

    // Control register; the bit positions are decoded by the channel logic.
    typedef struct packed {
        logic [LO_W-1:0] addr;
        logic            smm;
        logic            bs16;
        logic            mem;
        logic            rdy_ext;
        logic [1:0]      rsvd;
        logic [WS_W-1:0] ws;
    } ctl_reg_t;

    // Mask register: address don't-cares, management-mode don't-care, spare.
    typedef struct packed {
        logic [LO_W-1:0] addr_m;
        logic            smm_m;
        logic [9:0]      spare;
    } msk_reg_t;

    function automatic ctl_reg_t ctl_reset(input bit upper);
        return upper ? ctl_reg_t'(16'hFF6F) : ctl_reg_t'(16'h0000);
    endfunction
endpackage

// File: rtl/csel_regs.sv
// Control and mask register pair with a combinational read mux.
// Assumes writes take effect at the clock edge that samples reg_wr.
module csel_regs
    import csel_pkg::*;
#(
    parameter bit UPPER_CH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output ctl_reg_t         ctl_q,
    output msk_reg_t         msk_q,
    output logic [REG_W-1:0] rdata
);
    localparam ctl_reg_t CTL_RST = ctl_reset(UPPER_CH);

    // Register storage with the reset value chosen by UPPER_CH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            msk_q <= '0;
        end else if (wr) begin
            if (sel) msk_q <= msk_reg_t'(wdata);
            else     ctl_q <= ctl_reg_t'(wdata);
        end
    end

    // Read mux for the selected register.
    always_comb rdata = sel ? REG_W'(msk_q) : REG_W'(ctl_q);
endmodule

// File: rtl/csel_match.sv
// Masked address compare qualified by cycle type and management mode.
// Assumes ADDR_W >= 16; memory uses the top 15 address bits, I/O uses bits 15:1.
module csel_match
    import csel_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [CH_W-1:0]   ch_addr,
    input  logic [CH_W-1:0]   ch_mask,
    input  logic              q_smm,
    input  logic              q_smm_m,
    input  logic              q_mem,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_is_mem,
    input  logic              bus_smm,
    input  logic              bus_hold,
    output logic              hit
);
    localparam int MEM_LSB = ADDR_W - CH_W;

    logic [CH_W-1:0] cmp_addr;
    logic [CH_W-1:0] bit_ok;
    logic            smm_ok;

    // Pick the address window for the current cycle type.
    always_comb cmp_addr = bus_is_mem ? bus_addr[ADDR_W-1:MEM_LSB] : bus_addr[CH_W:1];

    // One compare cell per channel address bit.
    for (genvar i = 0; i < CH_W; i++) begin : g_bit
        assign bit_ok[i] = ch_mask[i] | (ch_addr[i] == cmp_addr[i]);
    end

    // Management-mode qualifier with its own don't-care.
    always_comb smm_ok = q_smm_m | (q_smm ? (bus_smm & ~bus_hold) : ~bus_smm);

    // Final hit: all bits agree, right cycle type, qualifier met.
    always_comb hit = (&bit_ok) & (bus_is_mem == q_mem) & smm_ok;

    logic unused_bit0;
    assign unused_bit0 = bus_addr[0];
endmodule

// File: rtl/csel_waitctl.sv
// Cycle tracker and wait-state down-counter.
// Assumes start is only raised while idle; ready sources are active low.
module csel_waitctl
    import csel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] ws,
    input  logic            ext_mode,
    input  logic            ext_rdy_n,
    output logic            active,
    output logic            int_rdy
);
    logic [WS_W-1:0] cnt_q;
    logic            at_zero;
    logic            done;

    // Count reached zero inside a live cycle, and the end condition.
    always_comb begin
        at_zero = active & (cnt_q == '0);
        done    = at_zero & (ext_mode ? ~ext_rdy_n : 1'b1);
        int_rdy = at_zero & ~ext_mode;
    end

    // Cycle state: load the count on start, count down, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= ws;
        end else if (done) begin
            active <= 1'b0;
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/csel_channel.sv
// Top of one chip-select channel: registers, decoder and wait control.
// Assumes bus_adv is a one-cycle pulse per bus cycle.
module csel_channel
    import csel_pkg::*;
#(
    parameter int ADDR_W   = 26,
    parameter bit UPPER_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [UP_W-1:0]   cfg_up_addr,
    input  logic [UP_W-1:0]   cfg_up_mask,
    input  logic              bus_adv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_is_mem,
    input  logic              bus_smm,
    input  logic              bus_hold,
    input  logic              ext_rdy_n,
    input  logic              bs8_n,
    output logic              cs_n,
    output logic              int_rdy_n,
    output logic              cyc_16
);
    ctl_reg_t ctl_q;
    msk_reg_t msk_q;
    logic     hit;
    logic     active;
    logic     int_rdy;

    csel_regs #(.UPPER_CH(UPPER_CH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .ctl_q(ctl_q), .msk_q(msk_q), .rdata(reg_rdata)
    );

    csel_match #(.ADDR_W(ADDR_W)) match_i (
        .ch_addr({cfg_up_addr, ctl_q.addr}), .ch_mask({cfg_up_mask, msk_q.addr_m}),
        .q_smm(ctl_q.smm), .q_smm_m(msk_q.smm_m), .q_mem(ctl_q.mem),
        .bus_addr(bus_addr), .bus_is_mem(bus_is_mem),
        .bus_smm(bus_smm), .bus_hold(bus_hold), .hit(hit)
    );

    csel_waitctl wait_i (
        .clk(clk), .rst_n(rst_n), .start(bus_adv & hit & ~active),
        .ws(ctl_q.ws), .ext_mode(ctl_q.rdy_ext), .ext_rdy_n(ext_rdy_n),
        .active(active), .int_rdy(int_rdy)
    );

    // Output drive: select, internal ready and width report.
    always_comb begin
        cs_n      = ~active;
        int_rdy_n = ~int_rdy;
        cyc_16    = active & ctl_q.bs16 & bs8_n;
    end

    logic unused_fields;
    assign unused_fields = ^{ctl_q.rsvd, msk_q.spare};
endmodule

// File: rtl/csel_channel_chk.sv
// Temporal checks on the channel ports, attached by bind.
module csel_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_adv,
    input logic cs_n,
    input logic int_rdy_n,
    input logic cyc_16
);
    AST_RDY_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !int_rdy_n |-> !cs_n); // R8
    AST_RDY_ENDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !int_rdy_n |=> cs_n); // R7
    AST_CS_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(bus_adv)); // R7
    AST_WIDE_ONLY_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !cyc_16); // R10
endmodule

bind csel_channel csel_channel_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_adv(bus_adv),
    .cs_n(cs_n), .int_rdy_n(int_rdy_n), .cyc_16(cyc_16)
);

// File: tb/csel_channel_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module csel_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata, up_rdata;
    logic [9:0]  cfg_up_addr = 10'h2A5, cfg_up_mask = '0;
    logic        bus_adv = 1'b0;
    logic [25:0] bus_addr = '0;
    logic        bus_is_mem = 1'b1, bus_smm = 1'b0, bus_hold = 1'b0;
    logic        ext_rdy_n = 1'b1, bs8_n = 1'b1;
    logic        cs_n, int_rdy_n, cyc_16;
    logic        up_cs_n, up_rdy_n, up_c16;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    csel_channel #(.ADDR_W(26), .UPPER_CH(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_up_addr(cfg_up_addr), .cfg_up_mask(cfg_up_mask),
        .bus_adv(bus_adv), .bus_addr(bus_addr), .bus_is_mem(bus_is_mem),
        .bus_smm(bus_smm), .bus_hold(bus_hold), .ext_rdy_n(ext_rdy_n),
        .bs8_n(bs8_n), .cs_n(cs_n), .int_rdy_n(int_rdy_n), .cyc_16(cyc_16));

    csel_channel #(.ADDR_W(26), .UPPER_CH(1'b1)) dut_up (
        .clk(clk), .rst_n(rst_n), .reg_wr(1'b0), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(up_rdata),
        .cfg_up_addr(cfg_up_addr), .cfg_up_mask(cfg_up_mask),
        .bus_adv(1'b0), .bus_addr(bus_addr), .bus_is_mem(bus_is_mem),
        .bus_smm(bus_smm), .bus_hold(bus_hold), .ext_rdy_n(ext_rdy_n),
        .bs8_n(bs8_n), .cs_n(up_cs_n), .int_rdy_n(up_rdy_n), .cyc_16(up_c16));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(input logic [4:0] a, input logic smm,
        input logic b16, input logic mem, input logic rx, input logic [4:0] ws);
        return {a, smm, b16, mem, rx, 2'b00, ws};
    endfunction

    function automatic logic [25:0] maddr(input logic [9:0] up, input logic [4:0] lo);
        return {up, lo, 11'h0};
    endfunction

    function automatic logic [25:0] iaddr(input logic [9:0] up, input logic [4:0] lo, input logic b0);
        return {10'h0, up, lo, b0};
    endfunction

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Issue one address-valid pulse and measure the resulting select window.
    task automatic run_cyc(input logic [25:0] a, input logic mem, input int adv_at,
        input int ext_pulse, input int ext_from,
        output int len, output int rpos, output int npul, output int c16);
        len = 0; rpos = 0; npul = 0; c16 = 0;
        @(negedge clk); bus_addr = a; bus_is_mem = mem; bus_adv = 1'b1;
        @(negedge clk); bus_adv = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (cs_n) break;
            len++;
            if (len == 1) c16 = int'(cyc_16);
            if (!int_rdy_n) begin npul++; rpos = len; end
            ext_rdy_n = !((len == ext_pulse) || (len >= ext_from));
            bus_adv = (len == adv_at);
            @(negedge clk);
        end
        bus_adv = 1'b0; ext_rdy_n = 1'b1;
    endtask

    task automatic t_reset();
        reg_sel = 1'b0; #1;
        check("R1 ctl reset general", reg_rdata, 16'h0000);
        check("R1 ctl reset upper", up_rdata, 16'hFF6F);
        reg_sel = 1'b1; #1;
        check("R1 mask reset", reg_rdata, 16'h0000);
        check("R1 cs_n idle", cs_n, 1);
        check("R1 int_rdy_n idle", int_rdy_n, 1);
    endtask

    task automatic t_regs();
        wr_reg(1'b0, 16'hA5E3);
        wr_reg(1'b1, 16'h5A5A);
        reg_sel = 1'b0; #1; check("R2 ctl readback with reserved", reg_rdata, 16'hA5E3);
        reg_sel = 1'b1; #1; check("R2 mask readback", reg_rdata, 16'h5A5A);
        wr_reg(1'b1, 16'h0000);
    endtask

    task automatic t_internal();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd3));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R7 len ws=3", l, 4); check("R8 rdy pos ws=3", r, 4);
        check("R8 one pulse", n, 1); check("R10 wide", c, 1);
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd0));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R8 len ws=0", l, 1); check("R8 rdy pos ws=0", r, 1);
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd31));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R8 len ws=31", l, 32); check("R8 rdy pos ws=31", r, 32);
    endtask

    task automatic t_mem_match();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd1));
        run_cyc(maddr(10'h2A5, 5'h12), 1, 0, 0, 99, l, r, n, c);
        check("R3 low bit mismatch", l, 0);
        wr_reg(1'b1, 16'h0800);
        run_cyc(maddr(10'h2A5, 5'h12), 1, 0, 0, 99, l, r, n, c);
        check("R3 masked low bit", l, 2);
        run_cyc(maddr(10'h2A5, 5'h11), 1, 0, 0, 99, l, r, n, c);
        check("R3 unmasked bit still compared", l, 0);
        wr_reg(1'b1, 16'h0000);
        run_cyc(maddr(10'h2A4, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R3 upper mismatch", l, 0);
        cfg_up_mask = 10'h001;
        run_cyc(maddr(10'h2A4, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R3 upper masked", l, 2);
        cfg_up_mask = 10'h000;
    endtask

    task automatic t_io_type();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h0B, 0, 1, 0, 0, 5'd1));
        run_cyc(iaddr(10'h2A5, 5'h0B, 1'b1), 0, 0, 0, 99, l, r, n, c);
        check("R4 io hit, bit0 ignored", l, 2);
        run_cyc(iaddr(10'h2A5, 5'h0A, 1'b0), 0, 0, 0, 99, l, r, n, c);
        check("R4 io mismatch", l, 0);
        run_cyc(maddr(10'h2A5, 5'h0B), 1, 0, 0, 99, l, r, n, c);
        check("R5 memory cycle on io channel", l, 0);
        wr_reg(1'b0, ctl(5'h0B, 0, 1, 1, 0, 5'd1));
        run_cyc(iaddr(10'h2A5, 5'h0B, 1'b0), 0, 0, 0, 99, l, r, n, c);
        check("R5 io cycle on memory channel", l, 0);
    endtask

    task automatic t_smm();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd0));
        bus_smm = 1'b1;
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R6 normal-mode channel in smm", l, 0);
        wr_reg(1'b0, ctl(5'h13, 1, 1, 1, 0, 5'd0));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R6 smm channel in smm", l, 1);
        bus_hold = 1'b1;
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R6 smm channel during hold", l, 0);
        bus_hold = 1'b0; bus_smm = 1'b0;
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R6 smm channel outside smm", l, 0);
        wr_reg(1'b1, 16'h0400);
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R6 qualifier masked", l, 1);
        wr_reg(1'b1, 16'h0000);
    endtask

    task automatic t_width();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd0));
        bs8_n = 1'b0;
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R10 narrow request", c, 0);
        bs8_n = 1'b1;
        wr_reg(1'b0, ctl(5'h13, 0, 0, 1, 0, 5'd0));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 99, l, r, n, c);
        check("R10 byte channel", c, 0);
    endtask

    task automatic t_external();
        int l, r, n, c;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 1, 5'd3));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 6, l, r, n, c);
        check("R9 stretched len", l, 6); check("R9 no internal ready", n, 0);
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 0, 1, l, r, n, c);
        check("R9 early ready waits for count", l, 4);
        run_cyc(maddr(10'h2A5, 5'h13), 1, 0, 2, 7, l, r, n, c);
        check("R9 early pulse ignored", l, 7);
    endtask

    task automatic t_readv();
        int l, r, n, c, seen;
        wr_reg(1'b0, ctl(5'h13, 0, 1, 1, 0, 5'd3));
        run_cyc(maddr(10'h2A5, 5'h13), 1, 2, 0, 99, l, r, n, c);
        check("R11 len unchanged", l, 4);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            if (!cs_n) seen++;
            @(negedge clk);
        end
        check("R11 no second cycle", seen, 0);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_internal();
        t_mem_match();
        t_io_type();
        t_smm();
        t_width();
        t_external();
        t_readv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule